// File: doc/BRIEF.md
# TDM Audio Transmit Serializer

This block turns a stream of parallel audio samples into a single serial data line for multi-slot TDM links and two-slot I2S or left-justified links. The bit clock and the frame strobes are produced elsewhere. The block samples them on its own system clock, picks one of several frame strobes, and on every launching edge of the bit clock it drives the next bit of the frame.

Each frame holds 1 to 16 slots of 16, 20, 24 or 32 bits. A configurable delay sets how many bit clocks pass after the frame start before the first data bit. A delay of one gives I2S framing and a delay of zero gives left-justified framing. The slots that carry data are chosen by an inverted-sense mask, which is then cut down to a channel count. Samples come in on a ready/valid port and are pulled only at the start of each active slot. A missing sample silences that slot and raises a sticky flag. A soft-reset request clears the serializer and releases itself after a fixed number of cycles.

Top module: `tdm_tx_serializer`

## Requirements
- R1: A frame carries `cfg_slots_m1`+1 slots back to back. Every launch after the last bit of the last slot drives 0 until the next frame start.
- R2: Slot width codes 0x04, 0x08, 0x0C and 0x10 select 16, 20, 24 and 32 bits. With any other code a frame start opens no frame: `sdata` stays 0 and no sample is requested.
- R3: The launch at which the frame starts is frame bit 0. The first data bit is at frame bit `cfg_first_bit`, so 1 gives I2S framing and 0 gives left-justified framing.
- R4: With `cfg_bclk_inv`=0 a rising `bclk` launches a bit, and with 1 a falling `bclk` does. `sdata` takes the new bit at the first `clk` edge that samples the launching level, and it holds its value at every other edge.
- R5: The sample is right-aligned in `s_data`. Its width W comes from `cfg_samp_code`, uses the same encoding as R2, and is clipped to the slot width. With `cfg_lsb_first`=0 bit W-1 is sent first; with 1, bit 0 is sent first. The slot bits after the sample are 0.
- R6: Setting bit i of `cfg_slot_mask` silences slot i: zeros for the whole slot and no sample request.
- R7: Among the slots that are unmasked and inside the frame, only the lowest `cfg_nchans` stay active. This is the same as clearing the highest active bit until at most `cfg_nchans` remain.
- R8: If an active slot begins while `s_valid` is low, the whole slot is sent as zeros and `underrun` is set. `underrun` stays set until a soft reset.
- R9: `s_ready` is high only in the launch cycle that begins an active slot. A sample is taken when `s_valid` is also high in that cycle.
- R10: `cfg_sync_sel`=0 detaches the block, so no frame ever starts. A value n from 1 to NSYNC selects `fsync_in[n-1]`. A frame starts at a launch where the selected line is 1 and was 0 at the previous launch.
- R11: `cfg_enable` is sampled at each frame start. Clearing it mid-frame lets the current frame finish, and frames that start while it is low send only zeros.
- R12: A one-cycle `cfg_soft_rst` pulse aborts any frame, clears `sdata` and `underrun`, and holds `rst_busy` high for RST_CYCLES cycles. `rst_busy` then clears itself. Reset leaves all outputs at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk | input | 1 | Bit clock, sampled on `clk` |
| fsync_in | input | NSYNC | Candidate frame-start strobes |
| cfg_enable | input | 1 | Serializer enable, sampled at frame start |
| cfg_soft_rst | input | 1 | Soft-reset request pulse |
| cfg_slots_m1 | input | 4 | Slots per frame minus one |
| cfg_width_code | input | 5 | Encoded slot width |
| cfg_samp_code | input | 5 | Encoded sample width |
| cfg_first_bit | input | FIRST_W | Bit clocks from frame start to first data bit |
| cfg_bclk_inv | input | 1 | Launch on falling instead of rising bclk |
| cfg_lsb_first | input | 1 | Send LSB first |
| cfg_slot_mask | input | 16 | Set bit silences the slot |
| cfg_nchans | input | 5 | Maximum number of active slots |
| cfg_sync_sel | input | 3 | Frame strobe select, 0 = detached |
| s_data | input | 32 | Sample, right-aligned |
| s_valid | input | 1 | Sample available |
| s_ready | output | 1 | Sample taken this cycle |
| sdata | output | 1 | Serial data line |
| underrun | output | 1 | Sticky missing-sample flag |
| rst_busy | output | 1 | Soft reset in progress |

## Verification
The hardest state to reach from the ports is a slot boundary that lands on a launch where the sample port is not ready. Masking and cropping must agree on the slot index there, and a slip by one launch would shift a whole slot. The bench drives the bit clock and strobes itself. It applies random slot counts, widths, offsets, masks, channel counts and polarities, and holds `s_valid` low on a random share of launches so that underruns land on many different slot indices. Directed cases add an enable drop in mid-frame, a soft reset in mid-frame, a detached sync select with noisy strobe lines, and an illegal width code.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;
  localparam int SLOTS   = 16;
  localparam int SLOT_W  = $clog2(SLOTS);
  localparam int DATA_W  = 32;
  localparam int BIT_W   = $clog2(DATA_W);
  localparam int SW_W    = BIT_W + 1;

  // encoded width to bit count, 0 for an illegal code
  function automatic logic [SW_W-1:0] slot_bits(input logic [4:0] code);
    case (code)
      5'h04:   return SW_W'(16);
      5'h08:   return SW_W'(20);
      5'h0C:   return SW_W'(24);
      5'h10:   return SW_W'(32);
      default: return '0;
    endcase
  endfunction

  function automatic logic [SLOTS-1:0] range_mask(input logic [SLOT_W-1:0] last);
    logic [SLOTS-1:0] r;
    for (int i = 0; i < SLOTS; i++) r[i] = (SLOT_W'(i) <= last);
    return r;
  endfunction

  // keep only the lowest n set bits
  function automatic logic [SLOTS-1:0] crop_active(input logic [SLOTS-1:0] act,
                                                   input logic [4:0] n);
    logic [SLOTS-1:0] r;
    logic [5:0]       cnt;
    r   = '0;
    cnt = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (act[i] && (cnt < {1'b0, n})) begin
        r[i] = 1'b1;
        cnt  = cnt + 6'd1;
      end
    end
    return r;
  endfunction

  function automatic logic pick_bit(input logic [DATA_W-1:0] d, input logic [BIT_W-1:0] idx,
                                    input logic [SW_W-1:0] sw, input logic lsb);
    logic [SW_W-1:0] p;
    if ({1'b0, idx} >= sw) return 1'b0;
    if (lsb) return d[idx];
    p = sw - SW_W'(1) - {1'b0, idx};
    return d[p[BIT_W-1:0]];
  endfunction
endpackage

// File: rtl/tdm_tx_edge.sv
module tdm_tx_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic bclk,
  input  logic bclk_inv,
  input  logic fs_line,
  output logic launch,
  output logic frame_start
);
  logic bclk_q, fs_prev;

  assign launch      = (bclk ^ bclk_q) & (bclk ^ bclk_inv);
  assign frame_start = launch & fs_line & ~fs_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q  <= 1'b0;
      fs_prev <= 1'b0;
    end else begin
      bclk_q <= bclk;
      if (clr)         fs_prev <= 1'b0;
      else if (launch) fs_prev <= fs_line;
    end
  end
endmodule

// File: rtl/tdm_tx_pos.sv
module tdm_tx_pos import tdm_tx_pkg::*; #(
  parameter int FIRST_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              launch,
  input  logic              frame_start,
  input  logic              enable,
  input  logic [FIRST_W-1:0] first_bit,
  input  logic [SLOT_W-1:0] slots_m1,
  input  logic [SW_W-1:0]   slot_w,
  output logic              nxt_live,
  output logic [SLOT_W-1:0] nxt_slot,
  output logic [BIT_W-1:0]  nxt_bit
);
  logic               run_q, done_q, n_run, n_done;
  logic [FIRST_W-1:0] dly_q, n_dly;
  logic [SLOT_W-1:0]  slot_q;
  logic [BIT_W-1:0]   bit_q;

  always_comb begin
    n_run    = run_q;
    n_done   = done_q;
    n_dly    = dly_q;
    nxt_slot = slot_q;
    nxt_bit  = bit_q;
    if (frame_start) begin
      n_run    = enable & (slot_w != '0);
      n_done   = 1'b0;
      n_dly    = first_bit;
      nxt_slot = '0;
      nxt_bit  = '0;
    end else if (run_q && !done_q) begin
      if (dly_q != '0) begin
        n_dly = dly_q - FIRST_W'(1);
      end else if ({1'b0, bit_q} == slot_w - SW_W'(1)) begin
        nxt_bit = '0;
        if (slot_q == slots_m1) n_done = 1'b1;
        else                    nxt_slot = slot_q + SLOT_W'(1);
      end else begin
        nxt_bit = bit_q + BIT_W'(1);
      end
    end
    nxt_live = n_run & ~n_done & (n_dly == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0; done_q <= 1'b0; dly_q <= '0; slot_q <= '0; bit_q <= '0;
    end else if (clr) begin
      run_q <= 1'b0; done_q <= 1'b0; dly_q <= '0; slot_q <= '0; bit_q <= '0;
    end else if (launch) begin
      run_q  <= n_run;
      done_q <= n_done;
      dly_q  <= n_dly;
      slot_q <= nxt_slot;
      bit_q  <= nxt_bit;
    end
  end
endmodule

// File: rtl/tdm_tx_serializer.sv
module tdm_tx_serializer import tdm_tx_pkg::*; #(
  parameter int NSYNC      = 7,
  parameter int FIRST_W    = 5,
  parameter int RST_CYCLES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bclk,
  input  logic [NSYNC-1:0]   fsync_in,
  input  logic               cfg_enable,
  input  logic               cfg_soft_rst,
  input  logic [3:0]         cfg_slots_m1,
  input  logic [4:0]         cfg_width_code,
  input  logic [4:0]         cfg_samp_code,
  input  logic [FIRST_W-1:0] cfg_first_bit,
  input  logic               cfg_bclk_inv,
  input  logic               cfg_lsb_first,
  input  logic [15:0]        cfg_slot_mask,
  input  logic [4:0]         cfg_nchans,
  input  logic [2:0]         cfg_sync_sel,
  input  logic [31:0]        s_data,
  input  logic               s_valid,
  output logic               s_ready,
  output logic               sdata,
  output logic               underrun,
  output logic               rst_busy
);
  localparam int RC_W = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;

  logic            busy_q, clr_w;
  logic [RC_W-1:0] rc_q;
  logic            fs_line, launch_raw, fstart_raw, launch_g, frame_start_g;
  logic [SW_W-1:0] slot_w, samp_raw, samp_w;
  logic [SLOTS-1:0] act_mask;
  logic            nxt_live, slot_begin, take, miss, nxt_val;
  logic [SLOT_W-1:0] nxt_slot;
  logic [BIT_W-1:0]  nxt_bit;
  logic [DATA_W-1:0] smp_q, new_smp, cur_smp;
  logic            sdata_q, underrun_q;

  // self-clearing soft reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rc_q   <= '0;
    end else if (cfg_soft_rst) begin
      busy_q <= 1'b1;
      rc_q   <= RC_W'(RST_CYCLES - 1);
    end else if (busy_q) begin
      if (rc_q == '0) busy_q <= 1'b0;
      else            rc_q   <= rc_q - RC_W'(1);
    end
  end
  assign clr_w    = cfg_soft_rst | busy_q;
  assign rst_busy = busy_q;

  always_comb begin
    fs_line = 1'b0;
    for (int i = 0; i < NSYNC; i++)
      if (cfg_sync_sel == 3'(i + 1)) fs_line = fsync_in[i];
  end

  tdm_tx_edge u_edge (
    .clk(clk), .rst_n(rst_n), .clr(clr_w), .bclk(bclk), .bclk_inv(cfg_bclk_inv),
    .fs_line(fs_line), .launch(launch_raw), .frame_start(fstart_raw)
  );
  assign launch_g      = launch_raw & ~clr_w;
  assign frame_start_g = fstart_raw & ~clr_w;

  assign slot_w   = slot_bits(cfg_width_code);
  assign samp_raw = slot_bits(cfg_samp_code);
  assign samp_w   = (samp_raw > slot_w) ? slot_w : samp_raw;
  assign act_mask = crop_active(~cfg_slot_mask & range_mask(cfg_slots_m1), cfg_nchans);

  tdm_tx_pos #(.FIRST_W(FIRST_W)) u_pos (
    .clk(clk), .rst_n(rst_n), .clr(clr_w), .launch(launch_g), .frame_start(frame_start_g),
    .enable(cfg_enable), .first_bit(cfg_first_bit), .slots_m1(cfg_slots_m1),
    .slot_w(slot_w), .nxt_live(nxt_live), .nxt_slot(nxt_slot), .nxt_bit(nxt_bit)
  );

  assign slot_begin = launch_g & nxt_live & (nxt_bit == '0);
  assign s_ready    = slot_begin & act_mask[nxt_slot];
  assign take       = s_ready & s_valid;
  assign miss       = s_ready & ~s_valid;
  assign new_smp    = take ? s_data : '0;
  assign cur_smp    = slot_begin ? new_smp : smp_q;
  assign nxt_val    = nxt_live & act_mask[nxt_slot] &
                      pick_bit(cur_smp, nxt_bit, samp_w, cfg_lsb_first);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q <= '0; sdata_q <= 1'b0; underrun_q <= 1'b0;
    end else if (clr_w) begin
      smp_q <= '0; sdata_q <= 1'b0; underrun_q <= 1'b0;
    end else begin
      if (slot_begin) smp_q      <= new_smp;
      if (launch_g)   sdata_q    <= nxt_val;
      if (miss)       underrun_q <= 1'b1;
    end
  end
  assign sdata    = sdata_q;
  assign underrun = underrun_q;
endmodule

// File: rtl/tdm_tx_chk.sv
module tdm_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       launch_g,
  input logic       frame_start_g,
  input logic       cfg_soft_rst,
  input logic       cfg_enable,
  input logic [2:0] cfg_sync_sel,
  input logic       rst_busy,
  input logic       sdata,
  input logic       s_ready,
  input logic       s_valid,
  input logic       underrun
);
  a_r4_hold_between_launches: assert property (@(posedge clk) disable iff (!rst_n)
    (!launch_g && !cfg_soft_rst && !rst_busy) |=> $stable(sdata));
  a_r8_flag_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ready && !s_valid && !cfg_soft_rst) |=> underrun);
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && !cfg_soft_rst && !rst_busy) |=> underrun);
  a_r10_detached: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_sync_sel == 3'd0) |-> !frame_start_g);
  a_r11_disabled_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start_g && !cfg_enable) |=> !sdata);
  a_r12_quiet_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    rst_busy |-> (!sdata && !s_ready));
  a_r12_flag_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_busy) |-> !underrun);
endmodule

bind tdm_tx_serializer tdm_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .launch_g(launch_g), .frame_start_g(frame_start_g),
  .cfg_soft_rst(cfg_soft_rst), .cfg_enable(cfg_enable), .cfg_sync_sel(cfg_sync_sel),
  .rst_busy(rst_busy), .sdata(sdata), .s_ready(s_ready), .s_valid(s_valid),
  .underrun(underrun)
);

// File: tb/tdm_tx_serializer_tb.sv
`timescale 1ns/1ps
module tdm_tx_serializer_tb;
  localparam int NSYNC = 7;
  localparam int RSTC  = 8;

  logic clk = 1'b0, rst_n = 1'b0, bclk = 1'b0;
  logic [NSYNC-1:0] fsync_in = '0;
  logic cfg_enable = 1'b0, cfg_soft_rst = 1'b0, cfg_bclk_inv = 1'b0, cfg_lsb_first = 1'b0;
  logic [3:0]  cfg_slots_m1 = '0;
  logic [4:0]  cfg_width_code = 5'h04, cfg_samp_code = 5'h04, cfg_first_bit = '0, cfg_nchans = 5'd2;
  logic [15:0] cfg_slot_mask = '0;
  logic [2:0]  cfg_sync_sel = 3'd1;
  logic [31:0] s_data = '0;
  logic s_valid = 1'b0;
  logic s_ready, sdata, underrun, rst_busy;

  tdm_tx_serializer #(.NSYNC(NSYNC), .FIRST_W(5), .RST_CYCLES(RSTC)) u_dut (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync_in(fsync_in), .cfg_enable(cfg_enable),
    .cfg_soft_rst(cfg_soft_rst), .cfg_slots_m1(cfg_slots_m1), .cfg_width_code(cfg_width_code),
    .cfg_samp_code(cfg_samp_code), .cfg_first_bit(cfg_first_bit), .cfg_bclk_inv(cfg_bclk_inv),
    .cfg_lsb_first(cfg_lsb_first), .cfg_slot_mask(cfg_slot_mask), .cfg_nchans(cfg_nchans),
    .cfg_sync_sel(cfg_sync_sel), .s_data(s_data), .s_valid(s_valid), .s_ready(s_ready),
    .sdata(sdata), .underrun(underrun), .rst_busy(rst_busy)
  );

  always #2 clk = ~clk;

  int nchk = 0, nfail = 0, vpct = 100;
  string tag = "R12";
  // model state
  int  k_m = 0;
  bit  on_m = 0, fsprev_m = 0, und_m = 0;
  logic [31:0] cur_m = '0;

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int m_w(input logic [4:0] c);
    if (c == 5'h04) return 16;
    if (c == 5'h08) return 20;
    if (c == 5'h0C) return 24;
    if (c == 5'h10) return 32;
    return 0;
  endfunction

  // active slots: unmasked, in range, then drop the highest until count fits
  function automatic logic [15:0] m_act();
    logic [15:0] a;
    a = ~cfg_slot_mask & 16'((32'h1 << (cfg_slots_m1 + 1)) - 1);
    while ($countones(a) > cfg_nchans)
      for (int i = 15; i >= 0; i--) if (a[i]) begin a[i] = 1'b0; break; end
    return a;
  endfunction

  task automatic tick(input bit fs);
    bit fs_cur, exp_rdy, exp_bit;
    int w, sw, j, sl, b;
    logic [15:0] act;
    @(negedge clk);
    bclk = cfg_bclk_inv;
    fsync_in = NSYNC'($urandom);
    if (cfg_sync_sel != 0) fsync_in[cfg_sync_sel-1] = fs;
    @(negedge clk);
    @(negedge clk);
    bclk = ~cfg_bclk_inv;
    fs_cur = (cfg_sync_sel == 0) ? 1'b0 : fsync_in[cfg_sync_sel-1];
    w = m_w(cfg_width_code);
    sw = m_w(cfg_samp_code); if (sw > w) sw = w;
    if (fs_cur && !fsprev_m) begin
      on_m = cfg_enable && (w != 0);
      k_m = 0;
    end else if (on_m) k_m++;
    fsprev_m = fs_cur;
    exp_rdy = 0; exp_bit = 0;
    act = m_act();
    if (on_m && k_m >= cfg_first_bit) begin
      j = k_m - cfg_first_bit; sl = j / w; b = j % w;
      if (sl <= cfg_slots_m1 && act[sl]) begin
        if (b == 0) begin
          exp_rdy = 1;
          cur_m = s_valid ? s_data : 32'h0;
          if (!s_valid) und_m = 1;
        end
        if (b < sw) exp_bit = cfg_lsb_first ? cur_m[b] : cur_m[sw-1-b];
      end
    end
    #1 chk("s_ready (R9)", 32'(s_ready), 32'(exp_rdy));
    @(posedge clk); #1;
    chk("sdata", 32'(sdata), 32'(exp_bit));
    if (exp_rdy && s_valid) s_data = $urandom;
    s_valid = (($urandom % 100) < vpct);
  endtask

  task automatic frame(input int len, input int drop_at, input int stop_at);
    for (int t = 0; t < len; t++) begin
      if (t == stop_at) return;
      if (t == drop_at) cfg_enable = 1'b0;
      tick(t == 0);
    end
  endtask

  function automatic int flen();
    return cfg_first_bit + (cfg_slots_m1 + 1) * ((m_w(cfg_width_code) == 0) ? 16 : m_w(cfg_width_code)) + 2;
  endfunction

  task automatic soft_reset();
    @(negedge clk); cfg_soft_rst = 1'b1;
    @(posedge clk); #1;
    chk("rst_busy set (R12)", 32'(rst_busy), 32'd1);
    chk("sdata in reset (R12)", 32'(sdata), 32'd0);
    @(negedge clk); cfg_soft_rst = 1'b0;
    repeat (RSTC) @(posedge clk);
    #1;
    chk("rst_busy self-clear (R12)", 32'(rst_busy), 32'd0);
    chk("underrun cleared (R12)", 32'(underrun), 32'd0);
    on_m = 0; fsprev_m = 0; und_m = 0;
  endtask

  task automatic cfg(input int sm1, input logic [4:0] wc, input logic [4:0] sc, input int fb,
                     input bit lsb, input bit inv, input logic [15:0] msk, input int nch, input int sel);
    @(negedge clk);
    cfg_slots_m1 = 4'(sm1); cfg_width_code = wc; cfg_samp_code = sc; cfg_first_bit = 5'(fb);
    cfg_lsb_first = lsb; cfg_bclk_inv = inv; cfg_slot_mask = msk; cfg_nchans = 5'(nch);
    cfg_sync_sel = 3'(sel); cfg_enable = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [4:0] codes [4];
    codes = '{5'h04, 5'h08, 5'h0C, 5'h10};
    void'($urandom(32'd20240611));
    s_data = $urandom; s_valid = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    tag = "R12";
    chk("reset sdata", 32'(sdata), 0);
    chk("reset underrun", 32'(underrun), 0);
    chk("reset rst_busy", 32'(rst_busy), 0);
    chk("reset s_ready", 32'(s_ready), 0);
    @(negedge clk); rst_n = 1'b1;

    // I2S: 2 slots x 16, offset 1, MSB first
    tag = "R3/R5";
    cfg(1, 5'h04, 5'h04, 1, 0, 0, 16'h0000, 2, 1);
    repeat (3) frame(flen(), -1, -1);
    // left-justified, LSB first, 24-bit slots with 20-bit samples, mask slot 1, crop to 2
    tag = "R1/R6/R7";
    cfg(3, 5'h0C, 5'h08, 0, 1, 0, 16'h0002, 2, 2);
    repeat (2) frame(flen() + 3, -1, -1);
    // falling-edge launch
    tag = "R4";
    cfg(2, 5'h08, 5'h10, 2, 0, 1, 16'h0000, 3, 5);
    repeat (2) frame(flen(), -1, -1);
    // illegal width code
    tag = "R2";
    cfg(1, 5'h05, 5'h04, 1, 0, 0, 16'h0000, 2, 1);
    repeat (2) frame(40, -1, -1);
    // detached sync with noisy strobes
    tag = "R10";
    cfg(1, 5'h04, 5'h04, 0, 0, 0, 16'h0000, 2, 0);
    repeat (2) frame(40, -1, -1);
    // enable dropped mid-frame
    tag = "R11";
    cfg(1, 5'h10, 5'h10, 1, 0, 0, 16'h0000, 2, 3);
    frame(flen(), 20, -1);
    frame(flen(), -1, -1);
    // underrun then soft reset
    tag = "R8";
    cfg(3, 5'h04, 5'h04, 1, 0, 0, 16'h0000, 4, 1);
    vpct = 40;
    repeat (2) frame(flen(), -1, -1);
    chk("underrun sticky", 32'(underrun), 32'(und_m));
    vpct = 100;
    frame(flen(), -1, -1);
    chk("underrun still set", 32'(underrun), 32'(und_m));
    tag = "R12";
    soft_reset();
    frame(flen(), -1, 10);
    soft_reset();
    repeat (30) tick(0);
    frame(flen(), -1, -1);

    // random configurations
    for (int n = 0; n < 10; n++) begin
      tag = "R1/R5/R7/R8";
      cfg($urandom % 8, codes[$urandom % 4], codes[$urandom % 4], $urandom % 4,
          $urandom % 2, $urandom % 2, 16'($urandom), $urandom % 17, 1 + $urandom % 7);
      vpct = 85 + $urandom % 16;
      repeat (2) frame(flen() + $urandom % 3, -1, -1);
      chk("underrun flag (R8)", 32'(underrun), 32'(und_m));
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule